// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block decides whether a pending interrupt should be taken. It holds a software interrupt request register and a current priority level register, and it watches a small set of external interrupt lines. When a check strobe arrives, for example after a return from an exception handler, it works out the highest pending priority level. It then compares that level with the current level.

If the pending level is strictly higher, the block pulses an interrupt-take output for one cycle. At the same time it latches a summary vector of every pending request and the winning level as the interrupt ID. If no request qualifies, both latched values keep their earlier contents. A nonzero asynchronous-trap request seen at a check cannot be served by this block, so it is flagged as unsupported.

Top module: `ipl_evaluator`

## Requirements
- R1: A write to the software request register keeps only bits 4 through 18 of the written value (mask 0x7fff0) and clears all other bits. The stored value is visible on `sw_req_o` one cycle after the write.
- R2: A pending software request at bit i (4..18) stands for priority level i-3. With no external line pending, the highest such level wins.
- R3: External line k stands for level EXT_LO+k (20..23 by default) and appears in the summary at bit EXT_LO+k. Any pending external line beats every software request, and the highest external line wins.
- R4: The summary is the OR of every pending software and external request, each at its own bit position.
- R5: `take_intr_o` is high for exactly the one cycle after a check, and only when the pending level is nonzero and strictly greater than the current level.
- R6: A write to the current priority level register keeps bits 4:0 of the write data. The stored level is visible on `cur_lvl_o` one cycle later.
- R7: When a check does not take an interrupt, or when no check arrives, `summary_o` and `intr_id_o` keep their previous values.
- R8: `ast_unsup_o` pulses for the one cycle after a check during which the asynchronous-trap request input was nonzero. It stays low otherwise.
- R9: A check uses the register contents held before its clock edge. A write in the same cycle as a check takes effect only from the next check onward.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 24 | Software request write data (bits 4..18 kept) |
| lvl_wr_en | input | 1 | Write strobe for the current priority level register |
| lvl_wr_data | input | 8 | Level write data (bits 4:0 kept) |
| ext_irq_i | input | 4 | External interrupt request lines |
| ast_req_i | input | 4 | Asynchronous-trap request register value |
| check_i | input | 1 | Evaluate-now strobe |
| take_intr_o | output | 1 | Interrupt-class trap request, one-cycle pulse |
| summary_o | output | 24 | Latched summary of pending requests |
| intr_id_o | output | 5 | Latched winning level |
| cur_lvl_o | output | 5 | Current priority level register |
| sw_req_o | output | 24 | Software request register |
| ast_unsup_o | output | 1 | Unsupported asynchronous-trap flag, one-cycle pulse |

## Verification
Every result is due exactly one clock after the edge that samples its cause. A check produces the take pulse, the latched summary and ID, and the unsupported flag at the next edge. A write appears on the register outputs at that same next edge. The bench drives inputs shortly after a rising edge. It updates its behavioural model at the same rising edge as the design and compares all outputs at the falling edge that follows, so each result is compared in the cycle it first becomes due. Directed sequences cover the equal-level case, a write in the same cycle as a check, external precedence and holding when nothing is taken. Random traffic follows.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  // Default geometry of the request and level space
  localparam int unsigned IPL_SW_LO  = 4;   // first software request bit
  localparam int unsigned IPL_SW_N   = 15;  // number of software requests
  localparam int unsigned IPL_EXT_LO = 20;  // first external request bit / level
  localparam int unsigned IPL_EXT_N  = 4;   // number of external lines
  localparam int unsigned IPL_LVL_W  = 5;   // priority level width
  localparam int unsigned IPL_WR_W   = 8;   // level write-bus width
  localparam int unsigned IPL_AST_W  = 4;   // asynchronous-trap request width

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ipl_hi_enc.sv
module ipl_hi_enc #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]                      vec_i,
  output logic                              found_o,
  output logic [ipl_pkg::idx_width(N)-1:0]  idx_o
);
  localparam int unsigned IW = ipl_pkg::idx_width(N);

  // Highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ipl_ctl_regs.sv
module ipl_ctl_regs #(
  parameter int unsigned SW_LO  = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N   = ipl_pkg::IPL_SW_N,
  parameter int unsigned SUM_W  = 24,
  parameter int unsigned LVL_W  = ipl_pkg::IPL_LVL_W,
  parameter int unsigned WR_W   = ipl_pkg::IPL_WR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [SUM_W-1:0] sw_wr_data,
  input  logic             lvl_wr_en,
  input  logic [WR_W-1:0]  lvl_wr_data,
  output logic [SUM_W-1:0] sw_req_q,
  output logic [LVL_W-1:0] cur_lvl_q
);
  localparam logic [SUM_W-1:0] SW_MASK =
    ((SUM_W'(1) << SW_N) - SUM_W'(1)) << SW_LO;

  logic [SUM_W-1:0] sw_req_d;
  logic [LVL_W-1:0] cur_lvl_d;
  logic             unused_lvl_bits;

  assign unused_lvl_bits = ^lvl_wr_data[WR_W-1:LVL_W];

  // Next-state logic with explicit enables
  always_comb begin
    sw_req_d  = sw_req_q;
    cur_lvl_d = cur_lvl_q;
    if (sw_wr_en)  sw_req_d  = sw_wr_data & SW_MASK;
    if (lvl_wr_en) cur_lvl_d = lvl_wr_data[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req_q  <= '0;
      cur_lvl_q <= '0;
    end else begin
      sw_req_q  <= sw_req_d;
      cur_lvl_q <= cur_lvl_d;
    end
  end

  AST_LVL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_wr_en) |-> cur_lvl_q == $past(lvl_wr_data[LVL_W-1:0])); // R6

  AST_SWREQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_wr_en) |-> $stable(sw_req_q)); // R1
endmodule

// File: rtl/ipl_eval_core.sv
module ipl_eval_core #(
  parameter int unsigned SW_LO  = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N   = ipl_pkg::IPL_SW_N,
  parameter int unsigned EXT_LO = ipl_pkg::IPL_EXT_LO,
  parameter int unsigned EXT_N  = ipl_pkg::IPL_EXT_N,
  parameter int unsigned LVL_W  = ipl_pkg::IPL_LVL_W,
  parameter int unsigned SUM_W  = EXT_LO + EXT_N
) (
  input  logic [SUM_W-1:0] sw_req_i,
  input  logic [EXT_N-1:0] ext_irq_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  output logic [LVL_W-1:0] pend_lvl_o,
  output logic [SUM_W-1:0] summary_o,
  output logic             qualify_o
);
  localparam int unsigned SW_IW  = ipl_pkg::idx_width(SW_N);
  localparam int unsigned EXT_IW = ipl_pkg::idx_width(EXT_N);

  logic [SW_N-1:0]   sw_vec;
  logic              sw_found, ext_found;
  logic [SW_IW-1:0]  sw_idx;
  logic [EXT_IW-1:0] ext_idx;
  logic [SUM_W-1:0]  ext_placed;
  logic              unused_sw_bits;

  assign sw_vec = sw_req_i[SW_LO +: SW_N];

  // Bits outside the software field are cleared by the register; fold them away
  generate
    if (SW_LO > 0) begin : g_low_unused
      assign unused_sw_bits = ^sw_req_i[SW_LO-1:0];
    end else begin : g_no_low
      assign unused_sw_bits = 1'b0;
    end
  endgenerate

  ipl_hi_enc #(.N(SW_N)) u_sw_enc (
    .vec_i   (sw_vec),
    .found_o (sw_found),
    .idx_o   (sw_idx)
  );

  ipl_hi_enc #(.N(EXT_N)) u_ext_enc (
    .vec_i   (ext_irq_i),
    .found_o (ext_found),
    .idx_o   (ext_idx)
  );

  assign ext_placed = SUM_W'(ext_irq_i) << EXT_LO;

  // External lines take precedence over software requests
  always_comb begin
    if (ext_found)
      pend_lvl_o = LVL_W'(EXT_LO) + LVL_W'(ext_idx);
    else if (sw_found)
      pend_lvl_o = LVL_W'(sw_idx) + LVL_W'(1);
    else
      pend_lvl_o = '0;
    summary_o = sw_req_i | ext_placed;
    qualify_o = (pend_lvl_o != '0) && (pend_lvl_o > cur_lvl_i);
  end
endmodule

// File: rtl/ipl_evaluator.sv
module ipl_evaluator #(
  parameter int unsigned SW_LO  = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N   = ipl_pkg::IPL_SW_N,
  parameter int unsigned EXT_LO = ipl_pkg::IPL_EXT_LO,
  parameter int unsigned EXT_N  = ipl_pkg::IPL_EXT_N,
  parameter int unsigned LVL_W  = ipl_pkg::IPL_LVL_W,
  parameter int unsigned WR_W   = ipl_pkg::IPL_WR_W,
  parameter int unsigned AST_W  = ipl_pkg::IPL_AST_W,
  localparam int unsigned SUM_W = EXT_LO + EXT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [SUM_W-1:0] sw_wr_data,
  input  logic             lvl_wr_en,
  input  logic [WR_W-1:0]  lvl_wr_data,
  input  logic [EXT_N-1:0] ext_irq_i,
  input  logic [AST_W-1:0] ast_req_i,
  input  logic             check_i,
  output logic             take_intr_o,
  output logic [SUM_W-1:0] summary_o,
  output logic [LVL_W-1:0] intr_id_o,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic [SUM_W-1:0] sw_req_o,
  output logic             ast_unsup_o
);
  logic [LVL_W-1:0] pend_lvl;
  logic [SUM_W-1:0] pend_sum;
  logic             qualify;

  logic             take_d, unsup_d;
  logic [SUM_W-1:0] sum_d;
  logic [LVL_W-1:0] id_d;

  ipl_ctl_regs #(
    .SW_LO (SW_LO), .SW_N (SW_N), .SUM_W (SUM_W),
    .LVL_W (LVL_W), .WR_W (WR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_data  (sw_wr_data),
    .lvl_wr_en   (lvl_wr_en),
    .lvl_wr_data (lvl_wr_data),
    .sw_req_q    (sw_req_o),
    .cur_lvl_q   (cur_lvl_o)
  );

  ipl_eval_core #(
    .SW_LO (SW_LO), .SW_N (SW_N), .EXT_LO (EXT_LO),
    .EXT_N (EXT_N), .LVL_W (LVL_W), .SUM_W (SUM_W)
  ) u_core (
    .sw_req_i   (sw_req_o),
    .ext_irq_i  (ext_irq_i),
    .cur_lvl_i  (cur_lvl_o),
    .pend_lvl_o (pend_lvl),
    .summary_o  (pend_sum),
    .qualify_o  (qualify)
  );

  // Next-state for the result registers
  always_comb begin
    take_d  = check_i && qualify;
    unsup_d = check_i && (ast_req_i != '0);
    sum_d   = summary_o;
    id_d    = intr_id_o;
    if (take_d) begin
      sum_d = pend_sum;
      id_d  = pend_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_intr_o <= 1'b0;
      ast_unsup_o <= 1'b0;
      summary_o   <= '0;
      intr_id_o   <= '0;
    end else begin
      take_intr_o <= take_d;
      ast_unsup_o <= unsup_d;
      summary_o   <= sum_d;
      intr_id_o   <= id_d;
    end
  end

  AST_TAKE_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr_o |-> $past(check_i)); // R5

  AST_ID_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr_o |-> (intr_id_o > $past(cur_lvl_o))); // R5

  AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_intr_o |-> ($stable(intr_id_o) && $stable(summary_o))); // R7

  AST_SUM_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr_o |-> (summary_o != '0)); // R4

  AST_UNSUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ast_unsup_o |-> ($past(check_i) && ($past(ast_req_i) != '0))); // R8
endmodule

// File: tb/ipl_evaluator_tb.sv
module ipl_evaluator_tb_top;
  localparam int SW_LO = 4, SW_N = 15, EXT_LO = 20, EXT_N = 4;
  localparam int LVL_W = 5, WR_W = 8, AST_W = 4, SUM_W = 24;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sw_wr_en, lvl_wr_en, check_i;
  logic [SUM_W-1:0] sw_wr_data;
  logic [WR_W-1:0]  lvl_wr_data;
  logic [EXT_N-1:0] ext_irq_i;
  logic [AST_W-1:0] ast_req_i;
  logic             take_intr_o, ast_unsup_o;
  logic [SUM_W-1:0] summary_o, sw_req_o;
  logic [LVL_W-1:0] intr_id_o, cur_lvl_o;

  always #2.5 clk = ~clk;   // 200 MHz

  ipl_evaluator dut_i (
    .clk, .rst_n, .sw_wr_en, .sw_wr_data, .lvl_wr_en, .lvl_wr_data,
    .ext_irq_i, .ast_req_i, .check_i, .take_intr_o, .summary_o,
    .intr_id_o, .cur_lvl_o, .sw_req_o, .ast_unsup_o
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string scen  = "R10 reset";

  // Behavioural reference model
  int m_sw, m_lvl, m_sum, m_id, m_take, m_unsup;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = 0; m_lvl = 0; m_sum = 0; m_id = 0; m_take = 0; m_unsup = 0;
    end else begin
      int lvl;
      int sum;
      lvl = 0;
      for (int i = SW_LO; i < SW_LO + SW_N; i++)
        if ((m_sw >> i) & 1) lvl = i - 3;
      for (int k = 0; k < EXT_N; k++)
        if (ext_irq_i[k]) lvl = EXT_LO + k;
      sum = m_sw | (int'(ext_irq_i) << EXT_LO);
      m_take  = (check_i && lvl != 0 && lvl > m_lvl) ? 1 : 0;
      if (m_take != 0) begin m_sum = sum; m_id = lvl; end
      m_unsup = (check_i && ast_req_i != 0) ? 1 : 0;
      if (sw_wr_en)  m_sw  = int'(sw_wr_data) & 32'h7fff0;
      if (lvl_wr_en) m_lvl = int'(lvl_wr_data) & 32'h1f;
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] cycle %0d: actual 0x%0h expected 0x%0h",
               req, scen, cyc, act, exp);
    end
  endtask

  // Compare all outputs mid-cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      cmp("R5 take",    int'(take_intr_o), m_take);
      cmp("R2 id",      int'(intr_id_o),   m_id);
      cmp("R4 summary", int'(summary_o),   m_sum);
      cmp("R6 level",   int'(cur_lvl_o),   m_lvl);
      cmp("R1 swreq",   int'(sw_req_o),    m_sw);
      cmp("R8 unsup",   int'(ast_unsup_o), m_unsup);
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      report();
    end
  end

  task automatic idle();
    sw_wr_en = 0; lvl_wr_en = 0; check_i = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic wr_sw(input logic [SUM_W-1:0] v);
    sw_wr_en = 1; sw_wr_data = v; step();
  endtask

  task automatic wr_lvl(input logic [WR_W-1:0] v);
    lvl_wr_en = 1; lvl_wr_data = v; step();
  endtask

  task automatic chk();
    check_i = 1; step(); step();
  endtask

  initial begin
    idle();
    sw_wr_data = '0; lvl_wr_data = '0; ext_irq_i = '0; ast_req_i = '0;
    rst_n = 0;
    #12;
    // R10: all outputs zero while reset and after release
    n_vec++;
    if ({take_intr_o, ast_unsup_o, summary_o, intr_id_o, cur_lvl_o, sw_req_o} != '0) begin
      n_bad++;
      $display("FAIL R10 reset: actual nonzero outputs expected 0");
    end
    @(posedge clk); #1; rst_n = 1;
    step(); step();

    scen = "R1 mask";     wr_sw('1); step();
    scen = "R6 level";    wr_lvl(8'hff); step(); wr_lvl(8'h00);
    scen = "R5 nothing";  wr_sw('0); chk();
    scen = "R2 lowest";   wr_sw(24'h10); chk();
    scen = "R2 highest";  wr_sw(24'h40000); chk();
    scen = "R2 several";  wr_sw(24'h01110); chk();
    scen = "R5 equal";    wr_lvl(8'd15); wr_sw(24'h40000); chk();
    scen = "R7 hold";     step(); step(); chk();
    scen = "R5 above";    wr_lvl(8'd14); chk();
    scen = "R3 ext0";     wr_lvl(8'd0); ext_irq_i = 4'b0001; chk();
    scen = "R3 ext3";     ext_irq_i = 4'b1001; chk();
    scen = "R3 eqlvl";    wr_lvl(8'd23); chk();
    scen = "R9 samecyc";  wr_lvl(8'd0); ext_irq_i = 0;
    lvl_wr_en = 1; lvl_wr_data = 8'd31; check_i = 1; step(); step(); chk();
    scen = "R8 ast";      ast_req_i = 4'h2; step(); chk(); ast_req_i = 0; chk();

    scen = "random";
    for (int n = 0; n < 600; n++) begin
      sw_wr_en    = ($urandom_range(0, 3) == 0);
      sw_wr_data  = SUM_W'($urandom());
      lvl_wr_en   = ($urandom_range(0, 4) == 0);
      lvl_wr_data = WR_W'($urandom_range(0, 255));
      ext_irq_i   = ($urandom_range(0, 2) == 0) ? EXT_N'($urandom()) : '0;
      ast_req_i   = ($urandom_range(0, 7) == 0) ? AST_W'($urandom()) : '0;
      check_i     = ($urandom_range(0, 1) == 0);
      @(posedge clk); #1;
    end
    idle(); step(); step();
    report();
  end
endmodule